// File: doc/BRIEF.md
# DMA channel transfer trigger gate

This block decides when a single DMA channel is allowed to move data and how many data items each permission covers. It sits between the request sources and the channel datapath. In request-synchronized mode one request source triggers the channel. That source is either one of the hardware request lines, picked by a binary identifier, or a software request input. In free-running (memory-to-memory) mode the channel triggers itself whenever it is idle, and all requests are ignored.

Each trigger produces a one-cycle grant pulse. With the grant come a chunk item count, decoded from a 3-bit size code, and a latched direction flag. The datapath acknowledges each item it moves. After the last acknowledgement of the chunk the block pulses a done output and becomes idle again. Requests that arrive while a chunk is running are counted and served one per chunk afterwards. Dropping the enable input discards all pending and partial work.

Top module: `dma_trigger_gate`

## Requirements
- R1: After reset, grant, busy, chunk_done and chunk_items are all 0.
- R2: chunk_items, latched at each grant, is 1, 2, 4, 8 or 16 for chunk_code 0, 1, 2, 3 or 4, and it is 1 for the reserved codes 5, 6 and 7.
- R3: With sync_mode=1 and sw_mode=0, a cycle with hw_req[req_sel] high is a request. Every other hw_req bit and sw_req are ignored.
- R4: With sync_mode=1 and sw_mode=1, a cycle with sw_req high is a request, and all hw_req bits are ignored.
- R5: With sync_mode=0 the channel needs no request: it grants in the cycle after it becomes idle while enabled. Requests seen during free-running cycles are not remembered after a change to sync_mode=1.
- R6: A trigger taken at a clock edge makes grant high for exactly that one following cycle, and busy stays high from then until the last item of the chunk is acknowledged.
- R7: Each cycle in which a request is high counts as one request. Requests seen while busy are stored, up to 2^PEND_W-1 (15 by default; further ones are dropped). Each stored request yields exactly one later grant, in the cycle after the running chunk ends. No request is served twice.
- R8: chunk_done pulses for one cycle after the item_ack that completes the chunk, and never before it. item_ack while idle has no effect.
- R9: While enable is 0, the block clears any running chunk and all stored requests, and it issues neither grant nor chunk_done. After enable returns, a new request starts a full new chunk.
- R10: chunk_items and dir_m2p (copy of dir_m2p_in, 1 = memory-to-peripheral, 0 = peripheral-to-memory) are sampled at the grant and hold for the whole chunk, even if the configuration inputs change during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low clears all state |
| sync_mode | input | 1 | 1 = request-synchronized, 0 = free-running |
| sw_mode | input | 1 | 1 = software request source, 0 = hardware line |
| req_sel | input | SEL_W (7) | Hardware request line identifier |
| hw_req | input | 2^SEL_W (128) | Hardware request lines |
| sw_req | input | 1 | Software request |
| chunk_code | input | 3 | Chunk size code |
| dir_m2p_in | input | 1 | Direction configuration |
| item_ack | input | 1 | Datapath moved one item |
| grant | output | 1 | One-cycle chunk grant pulse |
| busy | output | 1 | Chunk in progress |
| chunk_items | output | CODE_MAX+1 (5) | Items allowed by the current grant |
| dir_m2p | output | 1 | Direction latched at grant |
| chunk_done | output | 1 | One-cycle pulse after last item |

## Verification
The bench sweeps every request line identifier. Each line is driven against the complement of its own bit, which separates correct line selection from any other bit leaking through. Every size code, including the reserved ones, is run to completion with the done cycle checked per acknowledgement, so an off-by-one in the item count stands out. Stored-request tests use two spaced requests and a saturating burst, and count grants exactly, which shows lost and double-served requests apart. Further sequences use free-running mode, software requests, a mid-chunk disable, idle acknowledgements and configuration changes inside a chunk; each of them shows whether an input that must be ignored leaks into the output.

// File: rtl/dma_trigger_gate.sv
module dma_trigger_gate #(
  parameter int SEL_W    = 7,
  parameter int CODE_MAX = 4,
  parameter int PEND_W   = 4,
  localparam int NREQ    = 1 << SEL_W,
  localparam int CNT_W   = CODE_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_mode,
  input  logic             sw_mode,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [NREQ-1:0]  hw_req,
  input  logic             sw_req,
  input  logic [2:0]       chunk_code,
  input  logic             dir_m2p_in,
  input  logic             item_ack,
  output logic             grant,
  output logic             busy,
  output logic [CNT_W-1:0] chunk_items,
  output logic             dir_m2p,
  output logic             chunk_done
);

  localparam logic [PEND_W:0] PEND_MAX = (PEND_W+1)'((1 << PEND_W) - 1);

  logic [PEND_W-1:0] pend;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  size;
  logic [PEND_W:0]   pend_sum;
  logic              src, trig, start, last;

  assign src   = sw_mode ? sw_req : hw_req[req_sel];
  assign trig  = sync_mode ? (src || pend != '0) : 1'b1;
  assign start = enable && !busy && trig;
  assign last  = busy && item_ack && remain == CNT_W'(1);
  assign size  = (int'(chunk_code) <= CODE_MAX) ? (CNT_W'(1) << chunk_code) : CNT_W'(1);

  assign pend_sum = (PEND_W+1)'(pend) + (PEND_W+1)'(src) - (PEND_W+1)'(start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= 1'b0;
      busy        <= 1'b0;
      chunk_done  <= 1'b0;
      chunk_items <= '0;
      dir_m2p     <= 1'b0;
      remain      <= '0;
      pend        <= '0;
    end else if (!enable) begin
      grant      <= 1'b0;
      busy       <= 1'b0;
      chunk_done <= 1'b0;
      remain     <= '0;
      pend       <= '0;
    end else begin
      grant      <= start;
      chunk_done <= last;
      if (start) begin
        busy        <= 1'b1;
        remain      <= size;
        chunk_items <= size;
        dir_m2p     <= dir_m2p_in;
      end else if (busy && item_ack) begin
        remain <= remain - CNT_W'(1);
        if (last) busy <= 1'b0;
      end
      if (!sync_mode)
        pend <= '0;
      else if (pend_sum > PEND_MAX)
        pend <= PEND_MAX[PEND_W-1:0];
      else
        pend <= pend_sum[PEND_W-1:0];
    end
  end

endmodule

// File: rtl/dma_trigger_gate_chk.sv
module dma_trigger_gate_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             item_ack,
  input logic             grant,
  input logic             busy,
  input logic [CNT_W-1:0] chunk_items,
  input logic             dir_m2p,
  input logic             chunk_done
);

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!grant && !busy && !chunk_done)); // R9

  AST_ITEMS_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(chunk_items) == 1); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !grant) |-> ($stable(chunk_items) && $stable(dir_m2p))); // R10

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> ($past(item_ack) && !busy)); // R8

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant); // R6

  AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy); // R6

endmodule

bind dma_trigger_gate dma_trigger_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .item_ack(item_ack),
  .grant(grant), .busy(busy), .chunk_items(chunk_items),
  .dir_m2p(dir_m2p), .chunk_done(chunk_done)
);

// File: tb/sim_dma_trigger_gate.sv
`timescale 1ns/1ps
module sim_dma_trigger_gate;
  localparam int SEL_W = 7;
  localparam int NREQ  = 1 << SEL_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, enable, sync_mode, sw_mode, sw_req, dir_m2p_in, item_ack;
  logic [SEL_W-1:0] req_sel;
  logic [NREQ-1:0]  hw_req;
  logic [2:0]       chunk_code;
  logic grant, busy, dir_m2p, chunk_done;
  logic [4:0] chunk_items;

  dma_trigger_gate u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .sw_mode(sw_mode), .req_sel(req_sel), .hw_req(hw_req), .sw_req(sw_req),
    .chunk_code(chunk_code), .dir_m2p_in(dir_m2p_in), .item_ack(item_ack),
    .grant(grant), .busy(busy), .chunk_items(chunk_items),
    .dir_m2p(dir_m2p), .chunk_done(chunk_done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_hw(int b);
    hw_req[b] = 1'b1;
    tick();
    hw_req = '0;
  endtask

  task automatic ack_chunk(int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_ack = 1'b1;
      tick();
      chk(tag, int'(chunk_done), (i == n-1) ? 1 : 0);
      chk(tag, int'(busy), (i == n-1) ? 0 : 1);
    end
    item_ack = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; sync_mode = 0; sw_mode = 0; sw_req = 0;
    dir_m2p_in = 0; item_ack = 0; req_sel = '0; hw_req = '0; chunk_code = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 grant", int'(grant), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(chunk_done), 0);
    chk("R1 items", int'(chunk_items), 0);

    // R2: every size code, free-running
    for (int c = 0; c < 8; c++) begin
      int exp_n;
      exp_n = (c <= 4) ? (1 << c) : 1;
      chunk_code = 3'(c);
      enable = 1;
      tick();
      chk("R6 grant", int'(grant), 1);
      chk("R2 items", int'(chunk_items), exp_n);
      ack_chunk(exp_n, "R8 done");
      enable = 0;
      tick();
    end

    // R5: free-running needs no request, forgets requests
    sync_mode = 0; chunk_code = 1; req_sel = 5; enable = 1;
    tick();
    chk("R5 first grant", int'(grant), 1);
    ack_chunk(2, "R8 done");
    tick();
    chk("R5 back-to-back grant", int'(grant), 1);
    hw_req[5] = 1; sw_req = 1;
    tick(); tick();
    hw_req = '0; sw_req = 0; sync_mode = 1;
    ack_chunk(2, "R8 done");
    tick();
    chk("R5 no stored grant", int'(grant), 0);
    tick();
    chk("R5 idle", int'(busy), 0);
    enable = 0;
    tick();

    // R3: sweep every line against its complement
    sync_mode = 1; sw_mode = 0; chunk_code = 0; enable = 1;
    for (int s = 0; s < NREQ; s++) begin
      req_sel = SEL_W'(s);
      hw_req = ~(NREQ'(1) << s);
      sw_req = 1;
      tick();
      hw_req = '0; sw_req = 0;
      chk("R3 other lines", int'(grant), 0);
      tick();
      chk("R3 other lines busy", int'(busy), 0);
      pulse_hw(s);
      chk("R3 selected line", int'(grant), 1);
      ack_chunk(1, "R8 done");
    end

    // R4: software request source
    sw_mode = 1; req_sel = 3;
    hw_req = '1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 hw ignored", int'(grant) + int'(busy), 0);
    end
    hw_req = '0;
    sw_req = 1;
    tick();
    sw_req = 0;
    chk("R4 sw grant", int'(grant), 1);
    ack_chunk(1, "R8 done");
    sw_mode = 0;

    // R7: stored requests, exact count
    chunk_code = 1; req_sel = 9;
    pulse_hw(9);
    chk("R7 first grant", int'(grant), 1);
    pulse_hw(9);
    tick();
    pulse_hw(9);
    ack_chunk(2, "R8 done");
    tick();
    chk("R7 stored grant 1", int'(grant), 1);
    ack_chunk(2, "R8 done");
    tick();
    chk("R7 stored grant 2", int'(grant), 1);
    ack_chunk(2, "R8 done");
    tick(); tick();
    chk("R7 no extra grant", int'(grant) + int'(busy), 0);

    // R7: saturation at 15 stored requests
    chunk_code = 4;
    pulse_hw(9);
    chk("R7 sat grant", int'(grant), 1);
    hw_req[9] = 1;
    repeat (20) tick();
    hw_req = '0;
    chunk_code = 0;
    ack_chunk(16, "R8 done");
    for (int k = 0; k < 15; k++) begin
      tick();
      chk("R7 sat stored grant", int'(grant), 1);
      ack_chunk(1, "R8 done");
    end
    tick(); tick();
    chk("R7 sat limit", int'(grant) + int'(busy), 0);

    // R9: disable clears partial chunk and stored request
    chunk_code = 2;
    pulse_hw(9);
    chk("R9 grant", int'(grant), 1);
    item_ack = 1;
    tick();
    item_ack = 0;
    pulse_hw(9);
    enable = 0;
    tick();
    chk("R9 busy cleared", int'(busy), 0);
    chk("R9 no done", int'(chunk_done), 0);
    enable = 1;
    tick();
    chk("R9 stored cleared", int'(grant), 0);
    tick();
    chk("R9 stored cleared", int'(grant) + int'(busy), 0);
    pulse_hw(9);
    chk("R9 new grant", int'(grant), 1);
    chk("R9 full chunk", int'(chunk_items), 4);
    ack_chunk(4, "R9 full count");

    // R8: idle acknowledgements ignored
    item_ack = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 idle ack", int'(chunk_done), 0);
    end
    item_ack = 0;
    chunk_code = 1;
    pulse_hw(9);
    chk("R8 grant", int'(grant), 1);
    ack_chunk(2, "R8 full after idle ack");

    // R10: configuration held during a chunk
    chunk_code = 3; dir_m2p_in = 1;
    pulse_hw(9);
    chk("R10 grant", int'(grant), 1);
    chk("R10 dir", int'(dir_m2p), 1);
    chk("R10 items", int'(chunk_items), 8);
    chunk_code = 0; dir_m2p_in = 0;
    item_ack = 1;
    repeat (3) tick();
    item_ack = 0;
    chk("R10 items held", int'(chunk_items), 8);
    chk("R10 dir held", int'(dir_m2p), 1);
    ack_chunk(5, "R10 count held");
    pulse_hw(9);
    chk("R10 new dir", int'(dir_m2p), 0);
    chk("R10 new items", int'(chunk_items), 1);
    ack_chunk(1, "R8 done");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule